// File: doc/BRIEF.md
# Serial-Input Systolic Insertion Sorter

This block sorts a batch of keys that arrive one per clock cycle. The keys pass through a chain of identical cells. Each cell holds at most one key. A key enters at cell 0. When a cell receives a key, it keeps the smaller of its stored key and the arriving key, and registers the larger one for its right neighbour on the next cycle. An empty cell stores the first key that reaches it. An arriving key that equals the stored key moves on to the right. Sorting therefore happens while the keys are still arriving, with one comparison per cell per cycle.

A batch closes when the producer flags the final key with `in_last_i`, or when the chain is full. After the batch closes, the block waits until no key is still moving between cells. It then shifts the chain one cell to the left on every cycle. Cell 0 presents its key on the output with a valid strobe, so the keys leave smallest first. `busy_o` is high from the cycle after the closing key until the chain is empty again. While `busy_o` is high, input is refused.

Top module: `chain_sorter`

## Requirements
- R1: After reset is asserted, `busy_o` and `out_valid_o` are low, and the chain holds no key.
- R2: At all times the occupied cells hold keys that do not decrease from left to right, and a key in flight to cell i+1 is never smaller than the key held by cell i.
- R3: Occupied cells form a contiguous run that starts at cell 0. A cell forwards a key only while it holds one.
- R4: While `busy_o` is low, a cycle with `in_valid_i` high accepts `in_key_i` into the batch. An accepted key with `in_last_i` high closes the batch.
- R5: The accepted key that brings the batch size to NUM_CELLS closes the batch even when `in_last_i` is low.
- R6: `busy_o` is high in the cycle after the closing key is accepted and stays high until the batch has drained. Keys offered while `busy_o` is high are ignored and never appear on the output. No key moves between cells while output is being presented.
- R7: The batch leaves on `out_key_o` as one strobe per key on consecutive cycles, in ascending order, with duplicate keys repeated. `busy_o` falls in the cycle after the strobe stops.
- R8: `busy_o` falls no later than 2*NUM_CELLS+4 cycles after the closing key is accepted, so the total sort time is linear in the batch size.
- R9: No key is ever forwarded out of the last cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Key offered this cycle |
| in_key_i | input | KEY_W | Offered key |
| in_last_i | input | 1 | Offered key closes the batch |
| out_valid_o | output | 1 | Output key strobe |
| out_key_o | output | KEY_W | Sorted key, zero when not valid |
| busy_o | output | 1 | Batch settling or draining; input refused |

## Verification
The bench builds the block with NUM_CELLS = 9 and KEY_W = 8. With nine cells, the batches used in the checks can be:
- a full scrambled batch,
- a full reversed batch, which is the longest in-flight ripple for the latency bound,
- a full batch of equal keys.

Full batches are sent without the last flag, so the capacity close is exercised. A short batch with duplicates, a single-key batch, and keys offered while the block is busy cover the remaining corner cases.

// File: rtl/chain_sorter_pkg.sv
package chain_sorter_pkg;

  typedef enum logic [1:0] {
    PH_FILL   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_DRAIN  = 2'd2
  } phase_e;

endpackage

// File: rtl/sort_cell.sv
module sort_cell #(
  parameter int KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drain_i,
  input  logic             ins_v_i,
  input  logic [KEY_W-1:0] ins_k_i,
  input  logic             nbr_v_i,
  input  logic [KEY_W-1:0] nbr_k_i,
  output logic             held_v_o,
  output logic [KEY_W-1:0] held_k_o,
  output logic             fwd_v_o,
  output logic [KEY_W-1:0] fwd_k_o
);

  logic             held_v_q, fwd_v_q;
  logic [KEY_W-1:0] held_k_q, fwd_k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_v_q <= 1'b0;
      held_k_q <= '0;
      fwd_v_q  <= 1'b0;
      fwd_k_q  <= '0;
    end else if (drain_i) begin
      // shift toward the output end
      held_v_q <= nbr_v_i;
      held_k_q <= nbr_k_i;
      fwd_v_q  <= 1'b0;
    end else if (ins_v_i) begin
      if (!held_v_q) begin
        held_v_q <= 1'b1;
        held_k_q <= ins_k_i;
        fwd_v_q  <= 1'b0;
      end else if (ins_k_i < held_k_q) begin
        held_k_q <= ins_k_i;
        fwd_v_q  <= 1'b1;
        fwd_k_q  <= held_k_q;
      end else begin
        // ties move right: arrival order kept
        fwd_v_q  <= 1'b1;
        fwd_k_q  <= ins_k_i;
      end
    end else begin
      fwd_v_q <= 1'b0;
    end
  end

  assign held_v_o = held_v_q;
  assign held_k_o = held_k_q;
  assign fwd_v_o  = fwd_v_q;
  assign fwd_k_o  = fwd_k_q;

  // R3: forwarding only from an occupied cell
  p_fwd_needs_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_v_q |-> held_v_q);

endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import chain_sorter_pkg::*;
#(
  parameter int NUM_CELLS = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic in_last_i,
  input  logic any_fwd_i,
  input  logic head_v_i,
  output logic accept_o,
  output logic drain_o,
  output logic busy_o
);

  localparam int CNT_W = $clog2(NUM_CELLS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(NUM_CELLS - 1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             close_batch;

  assign accept_o    = in_valid_i && (state_q == PH_FILL);
  assign close_batch = accept_o && (in_last_i || (cnt_q == CNT_TOP));
  assign drain_o     = (state_q == PH_DRAIN);
  assign busy_o      = (state_q != PH_FILL);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PH_FILL: begin
        if (close_batch) begin
          state_d = PH_SETTLE;
          cnt_d   = '0;
        end else if (accept_o) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_SETTLE: if (!any_fwd_i) state_d = PH_DRAIN;
      PH_DRAIN:  if (!head_v_i)  state_d = PH_FILL;
      default:   state_d = PH_FILL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_FILL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R5: batch count never reaches the chain size
  p_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(NUM_CELLS));

  // R6: chain is quiet while presenting output
  p_quiet_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_DRAIN) |-> !any_fwd_i);

endmodule

// File: rtl/chain_sorter.sv
module chain_sorter #(
  parameter int NUM_CELLS = 9,
  parameter int KEY_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [KEY_W-1:0] in_key_i,
  input  logic             in_last_i,
  output logic             out_valid_o,
  output logic [KEY_W-1:0] out_key_o,
  output logic             busy_o
);

  // chain index 0 is the block input; cell i feeds index i+1
  logic [NUM_CELLS:0]            chain_v;
  logic [NUM_CELLS:0][KEY_W-1:0] chain_k;
  // held index NUM_CELLS is a permanently empty slot past the end
  logic [NUM_CELLS:0]            held_v;
  logic [NUM_CELLS:0][KEY_W-1:0] held_k;

  logic accept, drain, any_fwd;

  assign chain_v[0]        = accept;
  assign chain_k[0]        = in_key_i;
  assign held_v[NUM_CELLS] = 1'b0;
  assign held_k[NUM_CELLS] = '0;
  assign any_fwd           = |chain_v[NUM_CELLS:1];

  sort_ctrl #(
    .NUM_CELLS (NUM_CELLS)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .any_fwd_i  (any_fwd),
    .head_v_i   (held_v[0]),
    .accept_o   (accept),
    .drain_o    (drain),
    .busy_o     (busy_o)
  );

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    sort_cell #(
      .KEY_W (KEY_W)
    ) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .drain_i  (drain),
      .ins_v_i  (chain_v[i]),
      .ins_k_i  (chain_k[i]),
      .nbr_v_i  (held_v[i+1]),
      .nbr_k_i  (held_k[i+1]),
      .held_v_o (held_v[i]),
      .held_k_o (held_k[i]),
      .fwd_v_o  (chain_v[i+1]),
      .fwd_k_o  (chain_k[i+1])
    );

    // R2: a forwarded key is never below the key left behind
    p_fwd_ge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chain_v[i+1] |-> (chain_k[i+1] >= held_k[i]));
  end

  for (genvar i = 0; i + 1 < NUM_CELLS; i++) begin : g_pair
    // R2: held keys non-decreasing left to right
    p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (held_v[i] && held_v[i+1]) |-> (held_k[i] <= held_k[i+1]));
    // R3: occupied cells contiguous from cell 0
    p_fill_left_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      held_v[i+1] |-> held_v[i]);
  end

  assign out_valid_o = drain && held_v[0];
  assign out_key_o   = out_valid_o ? held_k[0] : '0;

  // R9: nothing leaves past the last cell
  p_no_spill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_v[NUM_CELLS]);

  // R7: block returns to idle right after the strobe ends
  p_idle_after_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |=> !busy_o);

endmodule

// File: tb/chain_sorter_test.sv
module chain_sorter_test;

  localparam int N = 9;
  localparam int W = 8;
  localparam int NB = 5;
  localparam int LIMIT = 4 * N + 8;

  // byte j of a vector sits at bits [71-8j -: 8]
  localparam logic [71:0] VIN [NB] = '{
    72'h05_02_08_06_03_07_09_01_04,
    72'h90_80_70_60_50_40_30_20_10,
    72'h07_03_07_03_00_FF_00_00_00,
    72'hAA_00_00_00_00_00_00_00_00,
    72'h42_42_42_42_42_42_42_42_42
  };
  localparam logic [71:0] VEXP [NB] = '{
    72'h01_02_03_04_05_06_07_08_09,
    72'h10_20_30_40_50_60_70_80_90,
    72'h00_03_03_07_07_FF_00_00_00,
    72'hAA_00_00_00_00_00_00_00_00,
    72'h42_42_42_42_42_42_42_42_42
  };
  localparam int VLEN [NB] = '{9, 9, 6, 1, 9};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] in_key_i = '0;
  logic         in_last_i = 1'b0;
  logic         out_valid_o;
  logic [W-1:0] out_key_o;
  logic         busy_o;

  int checks = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  chain_sorter #(.NUM_CELLS(N), .KEY_W(W)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_key_i    (in_key_i),
    .in_last_i   (in_last_i),
    .out_valid_o (out_valid_o),
    .out_key_o   (out_key_o),
    .busy_o      (busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // send len keys; last flag only when the batch is short (R5 covers full ones)
  task automatic send(input logic [71:0] v, input int len, input bit busy_junk);
    for (int j = 0; j < len; j++) begin
      @(negedge clk_i);
      check(busy_o == 1'b0, "R4 idle before key", busy_o, 0);
      in_valid_i = 1'b1;
      in_key_i   = v[71-8*j -: 8];
      in_last_i  = (j == len - 1) && (len < N);
    end
    @(negedge clk_i);
    check(busy_o == 1'b1, "R6 busy after close", busy_o, 1);
    in_valid_i = busy_junk;
    in_key_i   = 8'h01;
    in_last_i  = 1'b1;
  endtask

  task automatic collect(input logic [71:0] e, input int len);
    int  idx = 0;
    int  done_at = -1;
    bit  started = 0;
    bit  gap = 0;
    for (int c = 0; c < LIMIT; c++) begin
      if (c > 0) @(negedge clk_i);
      if (out_valid_o) begin
        if (idx < len)
          check(out_key_o == e[71-8*idx -: 8], "R7 sorted key", out_key_o, e[71-8*idx -: 8]);
        else
          check(1'b0, "R6 extra key out", out_key_o, 0);
        started = 1;
        idx++;
      end else if (started && idx < len) begin
        gap = 1;
      end
      if (!busy_o) begin
        done_at = c;
        break;
      end
    end
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
    check(idx == len, "R7 key count", idx, len);
    check(!gap, "R7 consecutive strobes", gap, 0);
    check(done_at >= 0 && done_at <= 2 * N + 4, "R8 linear finish", done_at, 2 * N + 4);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    check(out_valid_o == 1'b0, "R1 valid in reset", out_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0 && out_valid_o == 1'b0, "R1 idle after reset", busy_o, 0);

    // vector table: R2 R4 R5 R7 R8
    for (int b = 0; b < NB; b++) begin
      send(VIN[b], VLEN[b], 1'b0);
      collect(VEXP[b], VLEN[b]);
    end

    // R6: keys offered while busy are dropped
    send(72'h50_00_00_00_00_00_00_00_00, 1, 1'b1);
    collect(72'h50_00_00_00_00_00_00_00_00, 1);
    send(72'h20_00_00_00_00_00_00_00_00, 1, 1'b0);
    collect(72'h20_00_00_00_00_00_00_00_00, 1);

    // R1: reset in the middle of a batch empties the chain
    for (int j = 0; j < 3; j++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_key_i   = W'(8'h30 + j);
      in_last_i  = 1'b0;
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(busy_o == 1'b0 && out_valid_o == 1'b0, "R1 mid-batch reset", busy_o, 0);
    rst_ni = 1'b1;
    send(72'h11_00_00_00_00_00_00_00_00, 1, 1'b0);
    collect(72'h11_00_00_00_00_00_00_00_00, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule